// File: doc/BRIEF.md
# Indexed Attribute Register Port

This block is a small bank of display attribute registers reached by a CPU through one byte-wide write port. A single internal toggle decides what a write on that port means. In the index phase, the byte selects a register. In the data phase, the byte is stored into the selected register. Each accepted write flips the toggle. Software brings the toggle to a known state by reading the unrelated input status port, which always forces the index phase. A separate data read port returns the selected register and leaves the toggle alone.

The bank holds the following registers:
- sixteen 6-bit palette entries;
- an 8-bit mode control register;
- an 8-bit border (overscan) color;
- a plane enable register with a status selector field;
- a 4-bit pixel pan count;
- a 4-bit color select value.

A flag carried in the index byte tells the display side whether the palette is currently being loaded. That flag is driven out continuously.

Top module: `attr_index_port`

## Requirements
- R1: After reset, the toggle is in the index phase, every register holds zero, `pal_src` is 0 and `rd_data` is 0.
- R2: In the index phase, a write stores bits 4..0 of the byte as the register index and bit 5 as the palette source flag, then moves to the data phase. Bits 7..6 of the byte are ignored.
- R3: In the data phase, a write stores the byte into the selected register and returns the toggle to the index phase.
- R4: A strobe on `rd_status_stb` forces the index phase. A write presented in the same cycle is discarded.
- R5: A strobe on `rd_data_stb` places the selected register on `rd_data` one clock later and leaves the toggle unchanged.
- R6: Indices 0x00..0x0F are palette entries. Each keeps byte bits 5..0, and bits 7..6 read as zero.
- R7: The control registers keep these bits, and all other bits read as zero:
  - index 0x10 (mode) keeps every bit except bit 4, mask 0xEF;
  - index 0x11 (border) keeps all 8 bits;
  - index 0x12 (plane enable) keeps bits 5..0, mask 0x3F;
  - index 0x13 (pan) keeps bits 3..0;
  - index 0x14 (color select) keeps bits 3..0.
- R8: Data writes to indices 0x15..0x1F change no register, and reads of those indices return zero.
- R9: `pal_src` always equals bit 5 of the most recent index-phase write.
- R10: `rd_data` holds its value in every cycle without a data read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write byte |
| rd_data_stb | input | 1 | Read strobe for the data read port |
| rd_status_stb | input | 1 | Input status port read, clears the toggle |
| rd_data | output | 8 | Registered read data |
| pal_src | output | 1 | Palette address source flag |

## Verification
All-ones writes to every index read back the keep mask of each register, which separates correct field widths from wrong ones and shows reserved bits at zero. The patterns 0x55 and 0xAA on palette entries catch swapped or stuck bits that an all-ones pattern would hide. Ordered sequences expose the toggle state through later behaviour:
- a data read between index and data writes shows whether the read disturbs the toggle;
- a status read between writes shows whether the toggle is cleared;
- a status read in the same cycle as a write shows that the write is dropped.

Writes to the unused indices, followed by reads of real registers, show that stray writes land nowhere.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DW       = 8;
  localparam int IDX_W    = 5;
  localparam int PAL_N    = 16;
  localparam int PAL_W    = 6;
  localparam int CTRL_N   = 5;
  localparam int SRC_BIT  = 5;
  localparam logic [IDX_W-1:0] CTRL_BASE = IDX_W'(PAL_N);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PAL_N + CTRL_N - 1);

  // bits kept by each control register, 0 = mode, 1 = border, 2 = plane, 3 = pan, 4 = color select
  function automatic logic [DW-1:0] ctrl_mask(input int k);
    case (k)
      0:       ctrl_mask = 8'hEF;
      1:       ctrl_mask = 8'hFF;
      2:       ctrl_mask = 8'h3F;
      3:       ctrl_mask = 8'h0F;
      4:       ctrl_mask = 8'h0F;
      default: ctrl_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [SRC_BIT:0] wr_low,
  input  logic             rd_status_stb,
  input  logic             rd_data_stb,
  output logic             data_phase,
  output logic [IDX_W-1:0] idx,
  output logic             pal_src,
  output logic             data_we
);
  logic             phase_d;
  logic [IDX_W-1:0] idx_d;
  logic             src_d;
  logic             idx_en;
  logic             phase_en;
  logic             wr_ok;

  always_comb begin
    wr_ok    = wr_stb && !rd_status_stb;
    idx_en   = wr_ok && !data_phase;
    data_we  = wr_ok && data_phase;
    phase_en = wr_ok || rd_status_stb;
    phase_d  = rd_status_stb ? 1'b0 : !data_phase;
    idx_d    = wr_low[IDX_W-1:0];
    src_d    = wr_low[SRC_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_phase <= 1'b0;
    end else if (phase_en) begin
      data_phase <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      pal_src <= 1'b0;
    end else if (idx_en) begin
      idx     <= idx_d;
      pal_src <= src_d;
    end
  end

  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status_stb |=> !data_phase);
  assert_to_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_status_stb && !data_phase) |=> data_phase);
  assert_to_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_status_stb && data_phase) |=> !data_phase);
  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && !wr_stb && !rd_status_stb) |=> $stable(data_phase));
  assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && !rd_status_stb && !data_phase) |=> $stable(pal_src));
endmodule

// File: rtl/attr_bank.sv
module attr_bank
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_val
);
  localparam int PAL_SEL_W  = $clog2(PAL_N);
  localparam int CTRL_SEL_W = $clog2(CTRL_N);

  logic [PAL_N-1:0][PAL_W-1:0] pal_q, pal_d;
  logic [CTRL_N-1:0][DW-1:0]   ctl_q, ctl_d;
  logic                        pal_hit, ctl_hit;
  logic                        pal_en, ctl_en;
  logic [IDX_W-1:0]            ctl_off;
  logic [CTRL_SEL_W-1:0]       ctl_sel;
  logic [PAL_SEL_W-1:0]        pal_sel;

  always_comb begin
    pal_hit = (idx < CTRL_BASE);
    ctl_hit = (idx >= CTRL_BASE) && (idx <= LAST_IDX);
    ctl_off = idx - CTRL_BASE;
    ctl_sel = ctl_off[CTRL_SEL_W-1:0];
    pal_sel = idx[PAL_SEL_W-1:0];
    pal_en  = data_we && pal_hit;
    ctl_en  = data_we && ctl_hit;
  end

  always_comb begin
    pal_d = pal_q;
    pal_d[pal_sel] = wr_data[PAL_W-1:0];
  end

  generate
    for (genvar k = 0; k < CTRL_N; k++) begin : g_ctl_next
      always_comb begin
        if (ctl_sel == CTRL_SEL_W'(k)) begin
          ctl_d[k] = wr_data & ctrl_mask(k);
        end else begin
          ctl_d[k] = ctl_q[k];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q <= '0;
    end else if (pal_en) begin
      pal_q <= pal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    if (pal_hit) begin
      rd_val = {{(DW-PAL_W){1'b0}}, pal_q[pal_sel]};
    end else if (ctl_hit) begin
      rd_val = ctl_q[ctl_sel];
    end else begin
      rd_val = '0;
    end
  end

  assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && (idx > LAST_IDX)) |=> ($stable(pal_q) && $stable(ctl_q)));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> ($stable(pal_q) && $stable(ctl_q)));
endmodule

// File: rtl/attr_rd_port.sv
module attr_rd_port
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    rd_val,
  output logic [DW-1:0]    rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= rd_val;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (idx > LAST_IDX)) |=> (rd_data == '0));
endmodule

// File: rtl/attr_index_port.sv
module attr_index_port
  import attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_data_stb,
  input  logic          rd_status_stb,
  output logic [DW-1:0] rd_data,
  output logic          pal_src
);
  logic             data_phase;
  logic [IDX_W-1:0] idx;
  logic             data_we;
  logic [DW-1:0]    rd_val;

  attr_phase_ctl u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .wr_low        (wr_data[SRC_BIT:0]),
    .rd_status_stb (rd_status_stb),
    .rd_data_stb   (rd_data_stb),
    .data_phase    (data_phase),
    .idx           (idx),
    .pal_src       (pal_src),
    .data_we       (data_we)
  );

  attr_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (data_we),
    .idx     (idx),
    .wr_data (wr_data),
    .rd_val  (rd_val)
  );

  attr_rd_port u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_data_stb),
    .idx     (idx),
    .rd_val  (rd_val),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_attr_index_port.sv
module test_attr_index_port;
  localparam time TCK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_data_stb = 1'b0;
  logic       rd_status_stb = 1'b0;
  logic [7:0] rd_data;
  logic       pal_src;

  int total = 0;
  int bad = 0;

  // bench-side model
  logic [7:0] m_reg [32];
  logic [4:0] m_idx = 5'd0;
  logic       m_phase = 1'b0;
  logic       m_src = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend = 1'b0;

  attr_index_port i_attr_index_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data_stb(rd_data_stb), .rd_status_stb(rd_status_stb),
    .rd_data(rd_data), .pal_src(pal_src)
  );

  always #(TCK/2) clk = ~clk;

  function automatic logic [7:0] keep(input logic [4:0] i);
    if (i < 5'd16) return 8'h3F;           // R6
    case (i)                                // R7
      5'h10: return 8'hEF;
      5'h11: return 8'hFF;
      5'h12: return 8'h3F;
      5'h13: return 8'h0F;
      5'h14: return 8'h0F;
      default: return 8'h00;                // R8
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = b;
    if (!m_phase) begin
      m_idx = b[4:0]; m_src = b[5]; m_phase = 1'b1;
    end else begin
      if (m_idx <= 5'h14) m_reg[m_idx] = b & keep(m_idx);
      m_phase = 1'b0;
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input string req);
    @(negedge clk);
    rd_data_stb = 1'b1;
    exp_q.push_back(m_reg[m_idx]);
    tag_q.push_back(req);
    @(negedge clk);
    rd_data_stb = 1'b0;
  endtask

  task automatic status_rd();
    @(negedge clk);
    rd_status_stb = 1'b1; m_phase = 1'b0;
    @(negedge clk);
    rd_status_stb = 1'b0;
  endtask

  task automatic status_and_wr(input logic [7:0] b);
    @(negedge clk);
    rd_status_stb = 1'b1; wr_stb = 1'b1; wr_data = b; m_phase = 1'b0;
    @(negedge clk);
    rd_status_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic rd_at(input logic [4:0] i, input string req);
    wr({3'b000, i});
    rd(req);
    status_rd();
  endtask

  // monitor: compares one cycle after each read strobe
  always @(posedge clk) pend <= rd_data_stb;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(TCK * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 pal_src", {7'd0, pal_src}, 8'h00);
    for (int i = 0; i < 32; i++) rd_at(5'(i), "R1 reset value");

    // all-ones to every index, readback shows keep masks
    for (int i = 0; i < 32; i++) begin
      wr(8'(i)); wr(8'hFF);
    end
    for (int i = 0; i < 32; i++) rd_at(5'(i), (i < 16) ? "R6 palette mask" :
                                            (i < 21) ? "R7 control mask" : "R8 unused index");

    // patterns on palette, stray writes then recheck controls
    for (int i = 0; i < 16; i++) begin
      wr(8'(i)); wr((i % 2 == 0) ? 8'h55 : 8'hAA);
    end
    for (int i = 21; i < 32; i++) begin
      wr(8'(i)); wr(8'h00);
    end
    for (int i = 0; i < 21; i++) rd_at(5'(i), "R8 stray write no effect");

    // R9 palette source flag
    wr(8'h23);
    check("R9 pal_src set", {7'd0, pal_src}, 8'h01);
    wr(8'h2A);
    check("R9 pal_src held over data", {7'd0, pal_src}, 8'h01);
    rd("R3 data write with flag");
    wr(8'h05);
    check("R9 pal_src cleared", {7'd0, pal_src}, 8'h00);
    wr(8'h11);

    // R2 bits 7..6 ignored in index byte
    wr(8'hC4);
    check("R2 pal_src from bit5", {7'd0, pal_src}, 8'h00);
    wr(8'h12);
    rd("R2 index from bits 4..0");

    // R5 data read does not move the toggle
    wr(8'h11);
    rd("R5 read in data phase");
    wr(8'hAB);
    rd("R5 write after read taken as data");

    // R4 status read clears toggle
    wr(8'h12);
    status_rd();
    wr(8'h13);
    wr(8'h07);
    rd("R4 toggle cleared by status read");
    // R4 simultaneous status read and write
    wr(8'h13);
    status_and_wr(8'h0F);
    wr(8'h13);
    rd("R4 write dropped with status read");

    // R10 hold
    @(negedge clk);
    held = rd_data;
    repeat (3) begin
      wr(8'h00);
      @(negedge clk);
    end
    check("R10 rd_data held", rd_data, held);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R5 actual=%0d expected=0 pending reads", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule